// File: doc/BRIEF.md
# Two-Port Serial Adapter Control Register File

This block holds the host-visible control and status words of a two-channel serial adapter. A simple synchronous register bus reaches five 16-bit words. They cover:
- a heartbeat LED,
- one line-interface word per port,
- a global control word,
- a read-only status word.

Outside the register file, the block merges the two serial controllers' active-low interrupt requests into one host interrupt, gated by a master enable. It also turns each controller's general-purpose pin 7 into an RTS output and a pair of active-low line-driver enables. The pin-7 level, the port's duplex bit and its 4-wire/2-wire bit set those enables.

Software resets each serial controller through the control word. While a port's reset bit is set, that port's line-interface word is held at its power-up value. A write pulse and a read pulse each take a single cycle. Read data is registered and shows in the cycle after the read pulse.

Top module: `sercfg_regfile`

## Requirements
- R1: The word index is `bus_addr[ADDR_W-1:2]`. Index 0 is the LED word, 1 is the port-0 line word, 2 is the port-1 line word, 3 is the control word and 4 is the status word. Byte offset +2 aliases the same word, and every index of 5 or above reads 0x0000. `bus_rdata` loads the selected word on the clock edge where `bus_rd` is 1 and holds its value otherwise.
- R2: After reset the LED word reads 0x0000, both line words read 0x0007, the control word reads 0x0000 and `bus_rdata` is 0x0000.
- R3: Bits without a function ignore writes and read back as 0. The writable bits are:
  - LED word: bit 0.
  - Line words: bits 5:0.
  - Control word: bits 5, 4, 1 and 0.
- R4: The status word ignores writes. It reads `{2'b0, DEV_REV[2:0], DEV_ID[2:0], 6'b0, pend[1:0]}`, where `pend[p]` is 1 while `ctl_irq_n[p]` is 0.
- R5: LED word bit 0 is an active-low flash enable.
  - While it is 0, `led_on` inverts every CLK_HZ/2 cycles. The first inversion comes CLK_HZ/2 edges after the bit is cleared or reset is released.
  - While it is 1, `led_on` is 0 from the next edge, and the interval count restarts.
- R6: In each port's line word, bits 2:0 drive that port's 3-bit slice of `port_mode` and bit 3 drives `port_term[p]`.
- R7: Control bits 1:0 drive `ctl_rst[1:0]`, which is active high. While `ctl_rst[p]` is 1, port p's line word is reloaded with 0x0007 on every edge, and writes to that word have no effect.
- R8: `host_irq_n` is 0 exactly when control bit 4 (master enable) is 1 and at least one `ctl_irq_n` bit is 0. The status pend bits do not depend on the master enable.
- R9: `dma_abort` equals control bit 5.
- R10: For port p:
  - `rts[p]` equals `ctl_pin7[p]`.
  - `tx_en_n[p]` is 0 exactly when pin 7 is 1 and line bit 4 (duplex) is 1.
  - `rx_en_n[p]` is 1 exactly when pin 7 is 0, line bit 4 is 1 and line bit 5 (4-wire) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wr | input | 1 | Write pulse |
| bus_rd | input | 1 | Read pulse |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ctl_irq_n | input | 2 | Active-low interrupt request from each serial controller |
| ctl_pin7 | input | 2 | General-purpose pin 7 of each serial controller |
| ctl_rst | output | 2 | Reset to each serial controller, active high |
| dma_abort | output | 1 | DMA abort request |
| host_irq_n | output | 1 | Merged, masked host interrupt, active low |
| led_on | output | 1 | Heartbeat LED drive |
| port_mode | output | 6 | Line mode, 3 bits per port (port 0 in bits 2:0) |
| port_term | output | 2 | Terminator enable per port |
| tx_en_n | output | 2 | Transmit driver enable per port, active low |
| rx_en_n | output | 2 | Receive driver enable per port, active low |
| rts | output | 2 | RTS output per port |

## Verification
The bench builds the block with CLK_HZ = 16, which gives an 8-cycle heartbeat interval. Several full LED periods and a restart of the interval count on re-enable therefore fit in a short run. ADDR_W = 6 puts word indices 5 to 15 on the bus, so the zero-read region beyond the status word is exercised. DEV_ID = 2 and DEV_REV = 5 are two distinct, asymmetric values, so a swapped or shifted status field becomes visible.

// File: rtl/sercfg_pkg.sv
// Shared constants and types of the serial adapter control register file.
// Assumes 16-bit words and exactly two serial ports.
package sercfg_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 5;
    localparam int NPORT    = 2;
    localparam int LINE_W   = 6;

    localparam int IDX_LED   = 0;
    localparam int IDX_LINE0 = 1;
    localparam int IDX_LINE1 = 2;
    localparam int IDX_CTL   = 3;
    localparam int IDX_STAT  = 4;

    localparam logic [LINE_W-1:0] LINE_DFLT = 6'h07;

    typedef struct packed {
        logic             abort;
        logic             mie;
        logic [NPORT-1:0] sr;
    } ctl_t;

    function automatic logic [DATA_W-1:0] ctl_word(input ctl_t c);
        return {10'b0, c.abort, c.mie, 2'b0, c.sr};
    endfunction
endpackage

// File: rtl/sercfg_heartbeat.sv
// Heartbeat LED generator. While flash_off is low, led_on inverts every
// CLK_HZ/2 cycles. While flash_off is high, the LED is dark and the interval
// count is held at zero.
// Assumes CLK_HZ >= 2.
module sercfg_heartbeat #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flash_off,
    output logic led_on
);
    localparam int HALF  = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count half-period intervals and invert the LED at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || flash_off) begin
            cnt_q  <= '0;
            led_on <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            led_on <= ~led_on;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sercfg_port_line.sv
// One port's line-interface word and its driver-enable decode.
// Assumes wr_en is already qualified by the address decode. While force_dflt
// is high, the word is reloaded with its power-up value and writes are ignored.
module sercfg_port_line
    import sercfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wdata,
    input  logic              force_dflt,
    input  logic              pin7,
    output logic [LINE_W-1:0] line_q,
    output logic [2:0]        mode,
    output logic              term,
    output logic              tx_en_n,
    output logic              rx_en_n,
    output logic              rts
);
    logic duplex, four_wire;

    // Hold the line word; the controller reset wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n || force_dflt) line_q <= LINE_DFLT;
        else if (wr_en)           line_q <= wdata;
    end

    // Split the fields and decode the driver enables from pin 7.
    always_comb begin
        mode      = line_q[2:0];
        term      = line_q[3];
        duplex    = line_q[4];
        four_wire = line_q[5];
        rts       = pin7;
        tx_en_n   = ~(pin7 & duplex);
        rx_en_n   = ~pin7 & duplex & ~four_wire;
    end
endmodule

// File: rtl/sercfg_regfile.sv
// Control register file of a two-port serial adapter. It decodes a simple
// synchronous register bus, holds the LED, line and control words, builds the
// status word, and merges the controller interrupts into one masked host
// interrupt.
// Assumes single-cycle bus pulses and ADDR_W >= 5.
module sercfg_regfile
    import sercfg_pkg::*;
#(
    parameter int         CLK_HZ  = 100_000_000,
    parameter int         ADDR_W  = 6,
    parameter logic [2:0] DEV_ID  = 3'd1,
    parameter logic [2:0] DEV_REV = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [1:0]        ctl_irq_n,
    input  logic [1:0]        ctl_pin7,
    output logic [1:0]        ctl_rst,
    output logic              dma_abort,
    output logic              host_irq_n,
    output logic              led_on,
    output logic [5:0]        port_mode,
    output logic [1:0]        port_term,
    output logic [1:0]        tx_en_n,
    output logic [1:0]        rx_en_n,
    output logic [1:0]        rts
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              hit;
    logic              flash_off_q;
    ctl_t              ctl_q;
    logic              mie_q;
    logic [NPORT-1:0]  irq_pend;
    logic [NPORT-1:0]  line_wr;
    logic [LINE_W-1:0] line_word [NPORT];
    logic [15:0]       rd_mux;
    logic [11:0]       unused_bits;

    assign unused_bits = {bus_addr[1:0], bus_wdata[15:6]};

    // Word index decode; offsets at or above the status word plus one miss.
    always_comb begin
        widx = bus_addr[ADDR_W-1:2];
        hit  = widx < WIDX_W'(NUM_REGS);
    end

    // LED flash control word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                            flash_off_q <= 1'b0;
        else if (bus_wr && widx == WIDX_W'(IDX_LED))           flash_off_q <= bus_wdata[0];
    end

    // Global control word: controller resets, interrupt enable, DMA abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (bus_wr && widx == WIDX_W'(IDX_CTL)) begin
            ctl_q.sr    <= bus_wdata[1:0];
            ctl_q.mie   <= bus_wdata[4];
            ctl_q.abort <= bus_wdata[5];
        end
    end

    sercfg_heartbeat #(.CLK_HZ(CLK_HZ)) u_hb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flash_off (flash_off_q),
        .led_on    (led_on)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign line_wr[p] = bus_wr && widx == WIDX_W'(IDX_LINE0 + p);
            sercfg_port_line u_line (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (line_wr[p]),
                .wdata      (bus_wdata[LINE_W-1:0]),
                .force_dflt (ctl_q.sr[p]),
                .pin7       (ctl_pin7[p]),
                .line_q     (line_word[p]),
                .mode       (port_mode[3*p +: 3]),
                .term       (port_term[p]),
                .tx_en_n    (tx_en_n[p]),
                .rx_en_n    (rx_en_n[p]),
                .rts        (rts[p])
            );
        end
    endgenerate

    // Interrupt merge and control outputs.
    always_comb begin
        irq_pend   = ~ctl_irq_n;
        mie_q      = ctl_q.mie;
        host_irq_n = ~(ctl_q.mie & (|irq_pend));
        ctl_rst    = ctl_q.sr;
        dma_abort  = ctl_q.abort;
    end

    // Read multiplexer over the five words.
    always_comb begin
        rd_mux = '0;
        if (hit) begin
            case (widx)
                WIDX_W'(IDX_LED):   rd_mux = {15'b0, flash_off_q};
                WIDX_W'(IDX_LINE0): rd_mux = {10'b0, line_word[0]};
                WIDX_W'(IDX_LINE1): rd_mux = {10'b0, line_word[1]};
                WIDX_W'(IDX_CTL):   rd_mux = ctl_word(ctl_q);
                WIDX_W'(IDX_STAT):  rd_mux = {2'b0, DEV_REV, DEV_ID, 6'b0, irq_pend};
                default:            rd_mux = '0;
            endcase
        end
    end

    // Registered read data, held between read pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/sercfg_regfile_chk.sv
// Property checker for sercfg_regfile, attached through bind.
module sercfg_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic [15:0] bus_rdata,
    input logic [1:0]  ctl_irq_n,
    input logic [1:0]  ctl_pin7,
    input logic [1:0]  ctl_rst,
    input logic        host_irq_n,
    input logic        led_on,
    input logic [5:0]  port_mode,
    input logic [1:0]  port_term,
    input logic [1:0]  tx_en_n,
    input logic [1:0]  rx_en_n,
    input logic [1:0]  rts,
    input logic        mie,
    input logic        flash_off
);
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));                               // R1

    AST_LED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        flash_off |=> !led_on);                                         // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !host_irq_n |-> (mie && ctl_irq_n != 2'b11));                   // R8

    AST_IRQ_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mie && ctl_irq_n != 2'b11) |-> !host_irq_n);                   // R8

    generate
        for (genvar p = 0; p < 2; p++) begin : g_chk
            AST_LINE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
                ctl_rst[p] |=> (port_mode[3*p +: 3] == 3'b111 && !port_term[p])); // R7

            AST_TX_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
                !tx_en_n[p] |-> (rts[p] && ctl_pin7[p]));               // R10

            AST_RX_OFF_RTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                rx_en_n[p] |-> (!rts[p] && tx_en_n[p]));                // R10
        end
    endgenerate
endmodule

bind sercfg_regfile sercfg_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .ctl_irq_n  (ctl_irq_n),
    .ctl_pin7   (ctl_pin7),
    .ctl_rst    (ctl_rst),
    .host_irq_n (host_irq_n),
    .led_on     (led_on),
    .port_mode  (port_mode),
    .port_term  (port_term),
    .tx_en_n    (tx_en_n),
    .rx_en_n    (rx_en_n),
    .rts        (rts),
    .mie        (mie_q),
    .flash_off  (flash_off_q)
);

// File: tb/sercfg_regfile_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model of the register file runs beside
// the design and every output is compared on every clock.
module sercfg_regfile_tb_top;
    localparam int CLK_HZ = 16;
    localparam int HALF   = CLK_HZ / 2;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [1:0]        ctl_irq_n = 2'b11, ctl_pin7 = 2'b00;
    logic [1:0]        ctl_rst, port_term, tx_en_n, rx_en_n, rts;
    logic              dma_abort, host_irq_n, led_on;
    logic [5:0]        port_mode;

    int n_chk = 0, n_fail = 0;
    bit live = 0, done = 0;

    always #2 clk = ~clk;

    sercfg_regfile #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .DEV_ID(3'd2), .DEV_REV(3'd5)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_irq_n(ctl_irq_n),
        .ctl_pin7(ctl_pin7), .ctl_rst(ctl_rst), .dma_abort(dma_abort),
        .host_irq_n(host_irq_n), .led_on(led_on), .port_mode(port_mode),
        .port_term(port_term), .tx_en_n(tx_en_n), .rx_en_n(rx_en_n), .rts(rts)
    );

    // Reference state.
    bit        m_off, m_led, m_mie, m_abort;
    bit [1:0]  m_sr;
    bit [5:0]  m_line [2];
    int        m_cnt;
    bit [15:0] m_rdata;

    function automatic bit [15:0] mread(input int a);
        if (a >= 20) return 16'h0000;
        case (a / 4)
            0: return {15'b0, m_off};
            1: return {10'b0, m_line[0]};
            2: return {10'b0, m_line[1]};
            3: return {10'b0, m_abort, m_mie, 2'b0, m_sr};
            default: return (16'(5) << 11) | (16'(2) << 8) | {14'b0, ~ctl_irq_n};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_off = 0; m_led = 0; m_mie = 0; m_abort = 0; m_sr = 0;
            m_line[0] = 6'h07; m_line[1] = 6'h07; m_cnt = 0; m_rdata = 0;
        end else begin
            int a;
            a = int'(bus_addr);
            if (bus_rd) m_rdata = mread(a);
            for (int p = 0; p < 2; p++) begin
                if (m_sr[p]) m_line[p] = 6'h07;
                else if (bus_wr && a < 20 && a / 4 == p + 1) m_line[p] = bus_wdata[5:0];
            end
            if (m_off) begin
                m_cnt = 0; m_led = 0;
            end else begin
                m_cnt++;
                if (m_cnt == HALF) begin m_cnt = 0; m_led = !m_led; end
            end
            if (bus_wr && a / 4 == 0) m_off = bus_wdata[0];
            if (bus_wr && a / 4 == 3) begin
                m_sr = bus_wdata[1:0]; m_mie = bus_wdata[4]; m_abort = bus_wdata[5];
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        if (!live) return;
        check("R1 rdata", bus_rdata, m_rdata);
        check("R5 led", led_on, m_led);
        for (int p = 0; p < 2; p++) begin
            bit dx, fw;
            dx = m_line[p][4]; fw = m_line[p][5];
            check("R6 mode", port_mode[3*p +: 3], m_line[p][2:0]);
            check("R6 term", port_term[p], m_line[p][3]);
            check("R10 rts", rts[p], ctl_pin7[p]);
            check("R10 tx_en_n", tx_en_n[p], (ctl_pin7[p] && dx) ? 0 : 1);
            check("R10 rx_en_n", rx_en_n[p], (!ctl_pin7[p] && dx && !fw) ? 1 : 0);
        end
        check("R7 ctl_rst", ctl_rst, m_sr);
        check("R8 host_irq_n", host_irq_n, (m_mie && ctl_irq_n != 2'b11) ? 0 : 1);
        check("R9 dma_abort", dma_abort, m_abort);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int a, input int d);
        bus_addr = ADDR_W'(a); bus_wdata = 16'(d); bus_wr = 1;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd_check(input int a, input int exp, input string tag);
        bus_addr = ADDR_W'(a); bus_rd = 1;
        tick();
        bus_rd = 0;
        check(tag, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        bit [15:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        live = 1;
        tick();
        // R2: power-up values.
        check("R2 rdata reset", bus_rdata, 16'h0000);
        rd_check(16'h00, 16'h0000, "R2 led word");
        rd_check(16'h04, 16'h0007, "R2 line0 word");
        rd_check(16'h08, 16'h0007, "R2 line1 word");
        rd_check(16'h0C, 16'h0000, "R2 ctl word");
        // R4: status layout with no request pending.
        rd_check(16'h10, 16'h2A00, "R4 status idle");
        // R3: reserved bits.
        wr(16'h04, 16'hFFFF);
        rd_check(16'h04, 16'h003F, "R3 line0 mask");
        wr(16'h08, 16'hFFC0);
        rd_check(16'h08, 16'h0000, "R3 line1 mask");
        wr(16'h0C, 16'hFFCC);
        rd_check(16'h0C, 16'h0000, "R3 ctl reserved");
        // R1: aliases and the zero region.
        rd_check(16'h06, 16'h003F, "R1 alias line0");
        rd_check(16'h14, 16'h0000, "R1 empty 0x14");
        rd_check(16'h3E, 16'h0000, "R1 empty 0x3E");
        wr(16'h16, 16'hFFFF);
        rd_check(16'h04, 16'h003F, "R1 empty write no effect");
        // R4: writes ignored; pend bits.
        wr(16'h10, 16'hFFFF);
        rd_check(16'h12, 16'h2A00, "R4 status write ignored");
        ctl_irq_n = 2'b10;
        rd_check(16'h10, 16'h2A01, "R4 pend port0");
        ctl_irq_n = 2'b01;
        rd_check(16'h10, 16'h2A02, "R4 pend port1");
        // R8: masking.
        ctl_irq_n = 2'b00; tick();
        check("R8 masked", host_irq_n, 1);
        rd_check(16'h10, 16'h2A03, "R8 pend visible while masked");
        wr(16'h0C, 16'h0010); tick();
        check("R8 enabled", host_irq_n, 0);
        ctl_irq_n = 2'b11; tick();
        check("R8 idle", host_irq_n, 1);
        // R9
        wr(16'h0E, 16'h0030); tick();
        check("R9 abort set", dma_abort, 1);
        wr(16'h0C, 16'h0000);
        // R10: every pin7/duplex/wiring combination on both ports.
        for (int c = 0; c < 8; c++) begin
            wr(16'h04, (c & 3) << 4);
            wr(16'h08, (c & 3) << 4);
            ctl_pin7 = (c & 4) ? 2'b11 : 2'b00;
            tick();
        end
        // R7: reset forcing.
        wr(16'h04, 16'h003A);
        wr(16'h0C, 16'h0001); tick();
        check("R7 ctl_rst", ctl_rst, 2'b01);
        check("R7 forced mode", port_mode[2:0], 3'b111);
        wr(16'h04, 16'h0022);
        rd_check(16'h04, 16'h0007, "R7 write blocked");
        wr(16'h0C, 16'h0000);
        wr(16'h04, 16'h0022);
        rd_check(16'h04, 16'h0022, "R7 write after release");
        // R5: heartbeat.
        wr(16'h00, 16'h0001); tick();
        check("R5 dark", led_on, 0);
        wr(16'h00, 16'h0000);
        repeat (3 * HALF + 3) tick();
        wr(16'h02, 16'h0001);
        wr(16'h00, 16'h0000);
        repeat (HALF + 2) tick();
        // Mixed traffic.
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_addr  = ADDR_W'({lfsr[4:1], 1'b0} + (lfsr[5] ? 6'h10 : 6'h0));
            bus_wdata = {lfsr[7:0], lfsr[15:8]};
            if (bus_addr[4:2] == 3 && lfsr[9]) bus_wdata[1:0] = 0;
            bus_wr    = lfsr[6] & lfsr[11];
            bus_rd    = lfsr[8];
            ctl_irq_n = lfsr[13:12];
            ctl_pin7  = lfsr[15:14];
            tick();
        end
        bus_wr = 0; bus_rd = 0;
        tick();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule